// File: doc/BRIEF.md
# Bit-Serial Register Access Engine

This block is a bus peripheral that moves exactly one data bit for each strobe it receives from a host. The host drives an active-low chip select, an active-low read strobe and an active-low write strobe, all in Intel style, plus a single data bit. Every transaction opens with four write strobes that carry a register address, least significant bit first. After a data address, eight more strobes move one byte into or out of a small register space, also least significant bit first. The first strobe after the address sets the direction of the cycle.

Registers 0 to 9 hold two status bytes followed by eight time-and-date bytes. The two highest addresses are commands. The first of them hands the time-and-date bytes to an external clock unit and clears the second status register. The second loads those bytes back from a snapshot the clock unit presents. Each command is signalled to the clock unit as a one-cycle pulse. A lock bit in status register 0 blocks the hand-over command.

All strobe pins are asynchronous to the system clock. They pass through a synchronizer and an edge detector, and the synchronized rising edge of a strobe is the moment a bit transfers.

Top module: `bsr_engine`

## Requirements
- R1: After reset all ten registers read as zero, both command pulses are low, the time/date bus is zero and the engine waits for an address bit.
- R2: A rising write strobe while chip select is low takes the data pin as the next address bit. The four bits arrive in the order bit 0, 1, 2, 3.
- R3: A read strobe while the engine waits for address bits has no effect, because a read cannot open a cycle.
- R4: In a write cycle the eight write strobes after a data address carry data bit 0 first and bit 7 last, and the byte is stored when the eighth bit arrives.
- R5: In a read cycle the data output carries data bit n during the n-th read strobe, counting from 0. The output enable is high only while chip select and read strobe are both low.
- R6: A data cycle ends on its eighth data bit. The next write strobe is taken as address bit 0 of a new cycle.
- R7: Address 0xE with the lock clear (status register 0, bit 7) raises the load pulse for exactly one cycle and clears status register 1. Byte k of the 64-bit time/date bus always mirrors register k+2.
- R8: Address 0xE with the lock set raises no pulse and leaves status register 1 unchanged.
- R9: Address 0xF raises the fetch pulse for exactly one cycle and loads byte k of the snapshot input into register k+2. The two pulses are never high together.
- R10: Addresses 10 to 13 run full 12-bit cycles, but a read returns zero and a write changes no register.
- R11: Strobes that occur while chip select is high have no effect.
- R12: The first data strobe sets the direction of the cycle. After that, strobes of the other kind are ignored until the cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the strobe rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| rd_n_i | input | 1 | Read strobe, active low, asynchronous |
| wr_n_i | input | 1 | Write strobe, active low, asynchronous |
| dio_i | input | 1 | Data bit from the pad |
| dio_o | output | 1 | Data bit to the pad during read cycles |
| dio_oe_o | output | 1 | Pad driver enable |
| td_snap_i | input | 64 | Time/date snapshot from the clock unit, byte k for register k+2 |
| td_bus_o | output | 64 | Time/date registers toward the clock unit, byte k from register k+2 |
| cmd_load_o | output | 1 | One-cycle pulse: clock unit should take td_bus_o |
| cmd_fetch_o | output | 1 | One-cycle pulse: snapshot has been taken into the registers |

## Verification
The assertions check the command outputs on every cycle: the two pulses never overlap, each lasts exactly one cycle, and a pulse appears only when the engine is back at its address phase. They also check that a load pulse never appears while the lock bit is set, and that status register 1 is zero on the cycle after a load pulse. The bench scenarios cover what depends on the order of bits. These are the LSB-first assembly of addresses and data, the ignored read and deselected strobes, the direction latch, the idle address window 10 to 13, and the snapshot load. The bench sees these only by reading bytes back through the serial interface after a sweep over every address.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    // Phases of one serial communication cycle
    typedef enum logic [1:0] {
        PH_ADDR = 2'd0,   // collecting address bits
        PH_PEND = 2'd1,   // data address known, direction not yet fixed
        PH_RD   = 2'd2,   // shifting a byte out
        PH_WR   = 2'd3    // shifting a byte in
    } phase_e;

endpackage

// File: rtl/bsr_pin_sync.sv
module bsr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic rd_n_i,
    input  logic wr_n_i,
    input  logic dio_i,
    output logic wr_rise_o,
    output logic rd_rise_o,
    output logic din_o
);

    // Pin vector layout: bit 0 write, bit 1 read, bit 2 select, bit 3 data
    localparam int          NPIN    = 4;
    localparam logic [NPIN-1:0] IDLE_V = 4'b0111;

    logic [NPIN-1:0] pins;
    logic [NPIN-1:0] stage_d [STAGES];
    logic [NPIN-1:0] stage_q [STAGES];
    logic [NPIN-1:0] prev_d, prev_q;
    logic [NPIN-1:0] cur;

    assign pins = {dio_i, cs_n_i, rd_n_i, wr_n_i};

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = pins;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= IDLE_V;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign cur = stage_q[STAGES-1];

    always_comb prev_d = cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE_V;
        else        prev_q <= prev_d;
    end

    // A strobe counts on its rising edge only while select is low
    assign wr_rise_o = cur[0] & ~prev_q[0] & ~cur[2];
    assign rd_rise_o = cur[1] & ~prev_q[1] & ~cur[2];
    assign din_o     = cur[3];

endmodule

// File: rtl/bsr_seq.sv
module bsr_seq
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_rise_i,
    input  logic              rd_rise_i,
    input  logic              din_i,
    input  logic              lock_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              we_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              load_o,
    output logic              fetch_o,
    output logic              dout_o,
    output logic              idle_o
);

    localparam int CNT_W = (DATA_W > ADDR_W) ? $clog2(DATA_W) : $clog2(ADDR_W);
    localparam int AIX_W = $clog2(ADDR_W);
    localparam logic [ADDR_W-1:0] CODE_FETCH = '1;
    localparam logic [ADDR_W-1:0] CODE_LOAD  = CODE_FETCH - 1'b1;
    localparam logic [CNT_W-1:0]  ADDR_LAST  = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0]  DATA_LAST  = CNT_W'(DATA_W - 1);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  shift;
        logic               we;
        logic [DATA_W-1:0]  wdata;
        logic               load;
        logic               fetch;
    } seq_t;

    seq_t st_d, st_q;
    logic [ADDR_W-1:0] a_next;
    logic [DATA_W-1:0] sh_next;

    always_comb begin
        st_d       = st_q;
        st_d.we    = 1'b0;
        st_d.load  = 1'b0;
        st_d.fetch = 1'b0;
        a_next     = st_q.addr;
        sh_next    = st_q.shift;

        case (st_q.phase)
            PH_ADDR: begin
                if (wr_rise_i) begin
                    a_next[st_q.cnt[AIX_W-1:0]] = din_i;
                    st_d.addr = a_next;
                    if (st_q.cnt == ADDR_LAST) begin
                        st_d.cnt = '0;
                        if (a_next == CODE_LOAD) begin
                            st_d.load = ~lock_i;
                        end else if (a_next == CODE_FETCH) begin
                            st_d.fetch = 1'b1;
                        end else begin
                            st_d.phase = PH_PEND;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_PEND: begin
                if (wr_rise_i) begin
                    sh_next    = '0;
                    sh_next[0] = din_i;
                    st_d.shift = sh_next;
                    st_d.cnt   = CNT_W'(1);
                    st_d.phase = PH_WR;
                end else if (rd_rise_i) begin
                    st_d.cnt   = CNT_W'(1);
                    st_d.phase = PH_RD;
                end
            end
            PH_WR: begin
                if (wr_rise_i) begin
                    sh_next[st_q.cnt] = din_i;
                    st_d.shift = sh_next;
                    if (st_q.cnt == DATA_LAST) begin
                        st_d.we    = 1'b1;
                        st_d.wdata = sh_next;
                        st_d.cnt   = '0;
                        st_d.phase = PH_ADDR;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_RD: begin
                if (rd_rise_i) begin
                    if (st_q.cnt == DATA_LAST) begin
                        st_d.cnt   = '0;
                        st_d.phase = PH_ADDR;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_ADDR, cnt: '0, addr: '0, shift: '0,
                      we: 1'b0, wdata: '0, load: 1'b0, fetch: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o  = st_q.addr;
    assign we_o    = st_q.we;
    assign wdata_o = st_q.wdata;
    assign load_o  = st_q.load;
    assign fetch_o = st_q.fetch;
    assign idle_o  = (st_q.phase == PH_ADDR);
    assign dout_o  = (st_q.phase == PH_RD || st_q.phase == PH_PEND)
                     ? rdata_i[st_q.cnt] : 1'b0;

endmodule

// File: rtl/bsr_regfile.sv
module bsr_regfile #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 10,
    parameter int TD_BASE  = 2,
    parameter int LOCK_BIT = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [DATA_W-1:0]             wdata_i,
    output logic [DATA_W-1:0]             rdata_o,
    input  logic                          load_i,
    input  logic                          fetch_i,
    input  logic [(NUM_REGS-TD_BASE)*DATA_W-1:0] snap_i,
    output logic [(NUM_REGS-TD_BASE)*DATA_W-1:0] td_bus_o,
    output logic                          lock_o,
    output logic [DATA_W-1:0]             stat1_o
);

    localparam int TD_N     = NUM_REGS - TD_BASE;
    localparam int CLR_IDX  = 1;

    logic [DATA_W-1:0] regs_d [NUM_REGS];
    logic [DATA_W-1:0] regs_q [NUM_REGS];
    logic              addr_ok;

    assign addr_ok = (int'(addr_i) < NUM_REGS);

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) regs_d[i] = regs_q[i];
        if (fetch_i) begin
            for (int k = 0; k < TD_N; k++) regs_d[TD_BASE+k] = snap_i[k*DATA_W +: DATA_W];
        end else if (load_i) begin
            regs_d[CLR_IDX] = '0;
        end else if (we_i && addr_ok) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (addr_i == ADDR_W'(i)) regs_d[i] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= regs_d[i];
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr_i == ADDR_W'(i)) rdata_o = regs_q[i];
        end
    end

    genvar k;
    generate
        for (k = 0; k < TD_N; k++) begin : g_td
            assign td_bus_o[k*DATA_W +: DATA_W] = regs_q[TD_BASE+k];
        end
    endgenerate

    assign lock_o  = regs_q[0][LOCK_BIT];
    assign stat1_o = regs_q[CLR_IDX];

endmodule

// File: rtl/bsr_engine.sv
module bsr_engine #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 10,
    parameter int TD_BASE  = 2,
    parameter int LOCK_BIT = 7,
    parameter int SYNC_N   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n_i,
    input  logic        rd_n_i,
    input  logic        wr_n_i,
    input  logic        dio_i,
    output logic        dio_o,
    output logic        dio_oe_o,
    input  logic [(NUM_REGS-TD_BASE)*DATA_W-1:0] td_snap_i,
    output logic [(NUM_REGS-TD_BASE)*DATA_W-1:0] td_bus_o,
    output logic        cmd_load_o,
    output logic        cmd_fetch_o
);

    logic              wr_rise, rd_rise, din_s;
    logic              lock_w, seq_idle, we_w;
    logic [ADDR_W-1:0] addr_w;
    logic [DATA_W-1:0] wdata_w, rdata_w, stat1_w;

    bsr_pin_sync #(.STAGES(SYNC_N)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_i    (cs_n_i),
        .rd_n_i    (rd_n_i),
        .wr_n_i    (wr_n_i),
        .dio_i     (dio_i),
        .wr_rise_o (wr_rise),
        .rd_rise_o (rd_rise),
        .din_o     (din_s)
    );

    bsr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_rise_i (wr_rise),
        .rd_rise_i (rd_rise),
        .din_i     (din_s),
        .lock_i    (lock_w),
        .rdata_i   (rdata_w),
        .addr_o    (addr_w),
        .we_o      (we_w),
        .wdata_o   (wdata_w),
        .load_o    (cmd_load_o),
        .fetch_o   (cmd_fetch_o),
        .dout_o    (dio_o),
        .idle_o    (seq_idle)
    );

    bsr_regfile #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
        .TD_BASE(TD_BASE), .LOCK_BIT(LOCK_BIT)
    ) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (we_w),
        .addr_i   (addr_w),
        .wdata_i  (wdata_w),
        .rdata_o  (rdata_w),
        .load_i   (cmd_load_o),
        .fetch_i  (cmd_fetch_o),
        .snap_i   (td_snap_i),
        .td_bus_o (td_bus_o),
        .lock_o   (lock_w),
        .stat1_o  (stat1_w)
    );

    // Pad driver follows the raw pins so the bit appears as soon as read is low
    assign dio_oe_o = ~cs_n_i & ~rd_n_i;

endmodule

// File: rtl/bsr_engine_chk.sv
module bsr_engine_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load,
    input logic              fetch,
    input logic              idle,
    input logic              lock,
    input logic [DATA_W-1:0] stat1
);

    // R9: the two command pulses never coincide
    p_cmd_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load, fetch}));

    // R7: load pulse lasts a single cycle
    p_load_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);

    // R9: fetch pulse lasts a single cycle
    p_fetch_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |=> !fetch);

    // R7: status register 1 is zero right after a load
    p_stat1_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (stat1 == '0));

    // R8: no load pulse while the lock bit is set
    p_lock_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !lock);

    // R6: a command ends its cycle, so the engine is back at address phase
    p_cmd_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load || fetch) |-> idle);

endmodule

bind bsr_engine bsr_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cmd_load_o),
    .fetch (cmd_fetch_o),
    .idle  (seq_idle),
    .lock  (lock_w),
    .stat1 (stat1_w)
);

// File: tb/bsr_engine_tb_top.sv
`timescale 1ns/1ps
module bsr_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, din = 1'b0;
    logic        dout, doe;
    logic [63:0] snap = '0;
    logic [63:0] tdbus;
    logic        cload, cfetch;

    int n_chk = 0, n_fail = 0;
    int n_load = 0, n_fetch = 0, run_l = 0, run_f = 0, max_run = 0;
    logic [7:0] model [14];

    always #10 clk = ~clk;

    bsr_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .rd_n_i(rd_n), .wr_n_i(wr_n),
        .dio_i(din), .dio_o(dout), .dio_oe_o(doe), .td_snap_i(snap),
        .td_bus_o(tdbus), .cmd_load_o(cload), .cmd_fetch_o(cfetch)
    );

    always @(negedge clk) begin
        if (cload)  begin n_load++;  run_l++; end else run_l = 0;
        if (cfetch) begin n_fetch++; run_f++; end else run_f = 0;
        if (run_l > max_run) max_run = run_l;
        if (run_f > max_run) max_run = run_f;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_bit(input logic b, input logic sel_n = 1'b0);
        @(negedge clk); cs_n = sel_n; din = b;
        idle(2); wr_n = 1'b0;
        idle(4); wr_n = 1'b1;
        idle(5); cs_n = 1'b1;
        idle(5);
    endtask

    task automatic rd_bit(output logic b);
        @(negedge clk); cs_n = 1'b0;
        idle(2); rd_n = 1'b0;
        idle(3); b = dout;
        chk(doe == 1'b1, "R5 oe during read", doe, 1);
        rd_n = 1'b1;
        idle(1);
        chk(doe == 1'b0, "R5 oe after read", doe, 0);
        idle(4); cs_n = 1'b1;
        idle(5);
    endtask

    task automatic send_addr(input logic [3:0] a);
        for (int i = 0; i < 4; i++) wr_bit(a[i]);   // R2: LSB first
    endtask

    task automatic write_reg(input logic [3:0] a, input logic [7:0] v);
        send_addr(a);
        for (int i = 0; i < 8; i++) wr_bit(v[i]);   // R4: D0 first
    endtask

    task automatic read_reg(input logic [3:0] a, output logic [7:0] v);
        logic b;
        send_addr(a);
        for (int i = 0; i < 8; i++) begin rd_bit(b); v[i] = b; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic       b;
        int         l0, f0;

        idle(4); rst_n = 1'b1; idle(4);

        // R1: reset state
        chk(cload == 0 && cfetch == 0, "R1 pulses", {cload, cfetch}, 0);
        chk(tdbus == 0, "R1 td bus", tdbus, 0);
        chk(doe == 0, "R1 oe", doe, 0);
        for (int a = 0; a < 10; a++) begin
            read_reg(4'(a), v);
            chk(v == 0, "R1 reg zero", v, 0);
        end

        // R3: stray read strobe before address is ignored
        rd_bit(b);
        write_reg(4'd2, 8'hA5);
        read_reg(4'd2, v);
        chk(v == 8'hA5, "R3 read cannot open cycle", v, 8'hA5);

        // R11: write strobe with select high ignored
        wr_bit(1'b1, 1'b1);
        write_reg(4'd3, 8'h3C);
        read_reg(4'd3, v);
        chk(v == 8'h3C, "R11 deselected strobe", v, 8'h3C);

        // R2 R4 R5 R6 R10: sweep all data addresses, back to back cycles
        for (int a = 0; a < 14; a++) begin
            logic [7:0] w;
            w = 8'((a * 29 + 7) ^ (a << 4));
            if (a == 0) w[7] = 1'b0;
            model[a] = (a < 10) ? w : 8'h00;
            write_reg(4'(a), w);
        end
        for (int a = 0; a < 14; a++) begin
            read_reg(4'(a), v);
            chk(v == model[a], (a < 10) ? "R4 R5 R6 sweep" : "R10 unmapped zero", v, model[a]);
        end
        // R7: time/date bus mirrors registers 2..9
        for (int k = 0; k < 8; k++)
            chk(tdbus[k*8 +: 8] == model[k+2], "R7 td bus byte", tdbus[k*8 +: 8], model[k+2]);

        // R12: read strobe inside a write cycle is ignored
        send_addr(4'd4);
        for (int i = 0; i < 8; i++) begin
            wr_bit(1'(8'h96 >> i));
            if (i == 3) rd_bit(b);
        end
        read_reg(4'd4, v);
        chk(v == 8'h96, "R12 write keeps direction", v, 8'h96);
        // R12: write strobe inside a read cycle is ignored
        send_addr(4'd5);
        for (int i = 0; i < 8; i++) begin
            rd_bit(b); v[i] = b;
            if (i == 2) wr_bit(1'b1);
        end
        chk(v == model[5], "R12 read keeps direction", v, model[5]);
        write_reg(4'd6, 8'h5A);
        read_reg(4'd6, v);
        chk(v == 8'h5A, "R6 next cycle aligned", v, 8'h5A);

        // R7: load command clears status 1
        write_reg(4'd1, 8'h55);
        l0 = n_load; f0 = n_fetch;
        send_addr(4'hE); idle(10);
        chk(n_load == l0 + 1, "R7 load pulse count", n_load, l0 + 1);
        chk(n_fetch == f0, "R9 no fetch on load", n_fetch, f0);
        read_reg(4'd1, v);
        chk(v == 0, "R7 status1 cleared", v, 0);

        // R8: lock set blocks the load command
        write_reg(4'd1, 8'h66);
        write_reg(4'd0, 8'h80);
        l0 = n_load;
        send_addr(4'hE); idle(10);
        chk(n_load == l0, "R8 no pulse when locked", n_load, l0);
        read_reg(4'd1, v);
        chk(v == 8'h66, "R8 status1 kept", v, 8'h66);
        write_reg(4'd0, 8'h00);

        // R9: fetch command loads the snapshot
        snap = 64'h0123_4567_89AB_CDEF;
        f0 = n_fetch; l0 = n_load;
        send_addr(4'hF); idle(10);
        chk(n_fetch == f0 + 1, "R9 fetch pulse count", n_fetch, f0 + 1);
        chk(n_load == l0, "R9 no load on fetch", n_load, l0);
        for (int k = 0; k < 8; k++) begin
            read_reg(4'(k + 2), v);
            chk(v == snap[k*8 +: 8], "R9 snapshot byte", v, snap[k*8 +: 8]);
        end
        read_reg(4'd1, v);
        chk(v == 8'h66, "R9 status1 untouched", v, 8'h66);

        chk(max_run == 1, "R7 R9 pulse width", max_run, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule